// File: doc/BRIEF.md
# Switching Regulator Fault and Power-Good Supervisor

This block sequences a buck-boost regulator from shutdown through a soft-start ramp into regulation. It watches the regulator's protection flags and parks the power stage in a safe fault state when something goes wrong. All timing comes from a one-microsecond tick input, so three windows are counted in ticks: the soft-start limit, the overcurrent persistence filter and the automatic retry delay.

The analog side is outside this block. Comparators, the temperature sensor and the modulator reach it only as synchronous flags. The outputs drive the modulator (switching enable, reference ramp request, forced-PWM request), the pass-through switch, the output discharge path, and an open-drain power-good pin. Power-good is exposed as two signals: an active-low pull-down enable and a high-impedance indicator. Together they represent three pin conditions: floating, released high, and pulled low.

Pass-through mode bypasses the switching stage. In that mode only under-voltage and over-temperature can trip a fault. A sustained current limit is ignored.

Top module: `reg_supervisor`

## Requirements
- R1: While en_i is low, the block is in shutdown one clock later, whatever state it was in. In shutdown, switching, the ramp request and the pass-through switch are off, discharge is on, and power-good floats (pg_pd_no_o=1, pg_hiz_o=1). Every timer restarts from zero on the next enable. Shutdown is also the reset state.
- R2: When en_i is high, no protection flag is active and pt_req_i is low, the block leaves shutdown and enters soft-start one clock later. In soft-start, sw_en_o=1 and ss_ramp_o=1, discharge is off, and power-good is pulled low (pg_pd_no_o=0, pg_hiz_o=0).
- R3: In soft-start, vout_ok_i high moves the block to regulation on the next clock. In regulation, sw_en_o=1, ss_ramp_o=0, and power-good is released (pg_pd_no_o=1, pg_hiz_o=0).
- R4: If vout_ok_i never rises, the block enters the fault state on the SS_LIMIT_US-th tick (default 1000) counted from soft-start entry, and not earlier.
- R5: In soft-start or regulation, a fault is entered on the OC_LIMIT_US-th consecutive tick (default 700) with ilim_i high. A single clock with ilim_i low clears the count.
- R6: In any enabled state other than fault, including pass-through, uvlo_i high or ot_hot_i high enters the fault state one clock later. Over-temperature stays latched after ot_hot_i falls, until ot_cool_i is seen.
- R7: The fault state has all of switching, ramp request, pass-through switch and discharge off, and power-good pulled low.
- R8: In the fault state the block retries on the RETRY_US-th tick (default 30000) counted while no protection flag is active. The retry goes to soft-start, or to pass-through if pt_req_i is high. The retry count is held at zero while under-voltage or latched over-temperature is present.
- R9: With en_i high and no fault, pt_req_i high selects pass-through: pt_sw_o=1, sw_en_o=0, ss_ramp_o=0, power-good released. ilim_i has no effect there. Clearing pt_req_i returns the block to soft-start.
- R10: fpwm_o equals fpwm_req_i while pt_req_i is low, and is 0 while pt_req_i is high.
- R11: All three timers advance only on clocks where tick_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-microsecond timebase pulse |
| en_i | input | 1 | Regulator enable |
| uvlo_i | input | 1 | Input under-voltage flag |
| ot_hot_i | input | 1 | Die above trip temperature |
| ot_cool_i | input | 1 | Die cooled below restart temperature |
| ilim_i | input | 1 | Peak current limit active |
| vout_ok_i | input | 1 | Output has reached its target |
| pt_req_i | input | 1 | Pass-through mode request |
| fpwm_req_i | input | 1 | Forced PWM request |
| sw_en_o | output | 1 | Power stage switching enable |
| ss_ramp_o | output | 1 | Soft-start reference ramp request |
| pt_sw_o | output | 1 | Pass-through switch enable |
| dis_en_o | output | 1 | Output discharge enable |
| pg_pd_no_o | output | 1 | Power-good pull-down, active low |
| pg_hiz_o | output | 1 | Power-good pin floating |
| fpwm_o | output | 1 | Forced PWM request to the modulator |

## Verification
Bring-up is exercised three ways: with the output good arriving early, with it never arriving, and with enable dropped mid-ramp. Together these show that the timeout counts exactly 1000 ticks and restarts from zero. The overcurrent filter gets a run of 699 high ticks, then a single-clock gap, then a run of 700, which shows the count is consecutive rather than cumulative. The retry delay is run after a timeout, after held under-voltage, and after a one-clock over-temperature pulse. These cases separate a free-running retry count from one held by an active or latched flag. A sparse tick stream confirms that timing follows the tick rather than the clock.

// File: rtl/reg_sup_pkg.sv
package reg_sup_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_RAMP  = 3'd1,
    ST_REG   = 3'd2,
    ST_PASS  = 3'd3,
    ST_FAULT = 3'd4
  } sup_state_e;
endpackage

// File: rtl/sup_us_timer.sv
module sup_us_timer #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (tick_i && cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = tick_i && !clr_i && (cnt_q == LAST);

  AST_TIMER_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !tick_i) |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/sup_ot_latch.sv
module sup_ot_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hot_i,
  input  logic cool_i,
  output logic ot_active_o
);
  logic ot_q;

  // trip flag wins over the cool flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ot_q <= 1'b0;
    else if (hot_i)  ot_q <= 1'b1;
    else if (cool_i) ot_q <= 1'b0;
  end

  assign ot_active_o = ot_q | hot_i;

  AST_OT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ot_active_o && !cool_i) |=> ot_active_o); // R6
endmodule

// File: rtl/sup_fsm.sv
module sup_fsm
  import reg_sup_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       protect_i,
  input  logic       oc_done_i,
  input  logic       ss_done_i,
  input  logic       retry_done_i,
  input  logic       vout_ok_i,
  input  logic       pt_req_i,
  output sup_state_e state_o
);
  sup_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!en_i) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          if (protect_i)     state_d = ST_FAULT;
          else if (pt_req_i) state_d = ST_PASS;
          else               state_d = ST_RAMP;
        end
        ST_RAMP: begin
          if (protect_i || oc_done_i || ss_done_i) state_d = ST_FAULT;
          else if (pt_req_i)                       state_d = ST_PASS;
          else if (vout_ok_i)                      state_d = ST_REG;
        end
        ST_REG: begin
          if (protect_i || oc_done_i) state_d = ST_FAULT;
          else if (pt_req_i)          state_d = ST_PASS;
        end
        ST_PASS: begin
          if (protect_i)     state_d = ST_FAULT;
          else if (!pt_req_i) state_d = ST_RAMP;
        end
        ST_FAULT: begin
          if (retry_done_i) state_d = pt_req_i ? ST_PASS : ST_RAMP;
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  AST_EN_LOW_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> state_q == ST_OFF); // R1
  AST_RAMP_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == ST_RAMP && ss_done_i) |=> state_q == ST_FAULT); // R4
  AST_OC_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && oc_done_i && (state_q == ST_RAMP || state_q == ST_REG)) |=> state_q == ST_FAULT); // R5
  AST_PROTECT_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && protect_i && state_q != ST_FAULT) |=> state_q == ST_FAULT); // R6
  AST_RETRY_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == ST_FAULT && retry_done_i) |=> (state_q == ST_RAMP || state_q == ST_PASS)); // R8
  AST_PASS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == ST_PASS && !protect_i && pt_req_i) |=> state_q == ST_PASS); // R9
endmodule

// File: rtl/sup_out_dec.sv
module sup_out_dec
  import reg_sup_pkg::*;
(
  input  sup_state_e state_i,
  output logic       sw_en_o,
  output logic       ss_ramp_o,
  output logic       pt_sw_o,
  output logic       dis_en_o,
  output logic       pg_pd_no_o,
  output logic       pg_hiz_o
);
  always_comb begin
    sw_en_o    = 1'b0;
    ss_ramp_o  = 1'b0;
    pt_sw_o    = 1'b0;
    dis_en_o   = 1'b0;
    pg_pd_no_o = 1'b0;
    pg_hiz_o   = 1'b0;
    unique case (state_i)
      ST_OFF:   begin dis_en_o = 1'b1; pg_pd_no_o = 1'b1; pg_hiz_o = 1'b1; end
      ST_RAMP:  begin sw_en_o = 1'b1; ss_ramp_o = 1'b1; end
      ST_REG:   begin sw_en_o = 1'b1; pg_pd_no_o = 1'b1; end
      ST_PASS:  begin pt_sw_o = 1'b1; pg_pd_no_o = 1'b1; end
      ST_FAULT: ;
      default:  begin dis_en_o = 1'b1; pg_pd_no_o = 1'b1; pg_hiz_o = 1'b1; end
    endcase
  end
endmodule

// File: rtl/reg_supervisor.sv
module reg_supervisor
  import reg_sup_pkg::*;
#(
  parameter int unsigned SS_LIMIT_US = 1000,
  parameter int unsigned OC_LIMIT_US = 700,
  parameter int unsigned RETRY_US    = 30000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  input  logic uvlo_i,
  input  logic ot_hot_i,
  input  logic ot_cool_i,
  input  logic ilim_i,
  input  logic vout_ok_i,
  input  logic pt_req_i,
  input  logic fpwm_req_i,
  output logic sw_en_o,
  output logic ss_ramp_o,
  output logic pt_sw_o,
  output logic dis_en_o,
  output logic pg_pd_no_o,
  output logic pg_hiz_o,
  output logic fpwm_o
);
  sup_state_e state;
  logic ot_active, protect;
  logic ss_done, oc_done, retry_done;
  logic ss_clr, oc_clr, retry_clr, oc_watch;

  sup_ot_latch u_ot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hot_i       (ot_hot_i),
    .cool_i      (ot_cool_i),
    .ot_active_o (ot_active)
  );

  assign protect   = uvlo_i | ot_active;
  assign oc_watch  = (state == ST_RAMP) || (state == ST_REG);
  assign ss_clr    = !(en_i && state == ST_RAMP);
  assign oc_clr    = !(en_i && oc_watch && ilim_i);
  assign retry_clr = !(en_i && state == ST_FAULT && !protect);

  sup_us_timer #(.LIMIT(SS_LIMIT_US)) u_ss_tmr (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (ss_clr),
    .tick_i (tick_i), .done_o (ss_done)
  );

  sup_us_timer #(.LIMIT(OC_LIMIT_US)) u_oc_tmr (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (oc_clr),
    .tick_i (tick_i), .done_o (oc_done)
  );

  sup_us_timer #(.LIMIT(RETRY_US)) u_retry_tmr (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (retry_clr),
    .tick_i (tick_i), .done_o (retry_done)
  );

  sup_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .protect_i    (protect),
    .oc_done_i    (oc_done),
    .ss_done_i    (ss_done),
    .retry_done_i (retry_done),
    .vout_ok_i    (vout_ok_i),
    .pt_req_i     (pt_req_i),
    .state_o      (state)
  );

  sup_out_dec u_dec (
    .state_i    (state),
    .sw_en_o    (sw_en_o),
    .ss_ramp_o  (ss_ramp_o),
    .pt_sw_o    (pt_sw_o),
    .dis_en_o   (dis_en_o),
    .pg_pd_no_o (pg_pd_no_o),
    .pg_hiz_o   (pg_hiz_o)
  );

  assign fpwm_o = fpwm_req_i & ~pt_req_i;

  AST_OFF_OUTPUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (dis_en_o && pg_hiz_o && pg_pd_no_o && !sw_en_o && !pt_sw_o)); // R1
  AST_FAULT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && uvlo_i) |=> (!dis_en_o && !pg_pd_no_o && !sw_en_o && !pt_sw_o)); // R7
endmodule

// File: tb/reg_supervisor_test.sv
module reg_supervisor_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b1;
  logic en_i = 1'b0, uvlo_i = 1'b0, ot_hot_i = 1'b0, ot_cool_i = 1'b0;
  logic ilim_i = 1'b0, vout_ok_i = 1'b0, pt_req_i = 1'b0, fpwm_req_i = 1'b0;
  logic sw_en_o, ss_ramp_o, pt_sw_o, dis_en_o, pg_pd_no_o, pg_hiz_o, fpwm_o;

  int checks = 0;
  int errs = 0;

  // {sw_en, ss_ramp, pt_sw, dis_en, pg_pd_no, pg_hiz}
  localparam logic [5:0] E_OFF   = 6'b000111;
  localparam logic [5:0] E_RAMP  = 6'b110000;
  localparam logic [5:0] E_REG   = 6'b100010;
  localparam logic [5:0] E_PASS  = 6'b001010;
  localparam logic [5:0] E_FAULT = 6'b000000;

  always #5 clk = ~clk;

  reg_supervisor uut (
    .clk_i (clk), .rst_ni (rst_ni), .tick_i (tick_i), .en_i (en_i),
    .uvlo_i (uvlo_i), .ot_hot_i (ot_hot_i), .ot_cool_i (ot_cool_i),
    .ilim_i (ilim_i), .vout_ok_i (vout_ok_i), .pt_req_i (pt_req_i),
    .fpwm_req_i (fpwm_req_i), .sw_en_o (sw_en_o), .ss_ramp_o (ss_ramp_o),
    .pt_sw_o (pt_sw_o), .dis_en_o (dis_en_o), .pg_pd_no_o (pg_pd_no_o),
    .pg_hiz_o (pg_hiz_o), .fpwm_o (fpwm_o)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [5:0] exp);
    logic [5:0] got;
    got = {sw_en_o, ss_ramp_o, pt_sw_o, dis_en_o, pg_pd_no_o, pg_hiz_o};
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: outputs got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic chk_bit(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic go_off();
    en_i = 0; uvlo_i = 0; ot_hot_i = 0; ot_cool_i = 0;
    ilim_i = 0; vout_ok_i = 0; pt_req_i = 0; fpwm_req_i = 0; tick_i = 1;
    step(1);
    chk("R1 shutdown", E_OFF);
  endtask

  task automatic to_reg();
    en_i = 1; step(1);
    vout_ok_i = 1; step(1);
    chk("R3 regulation", E_REG);
  endtask

  task automatic t_bringup();
    en_i = 1; step(1);
    chk("R2 soft-start entry", E_RAMP);
    step(5);
    chk("R2 ramp holds", E_RAMP);
    vout_ok_i = 1; step(1);
    chk("R3 regulation", E_REG);
    fpwm_req_i = 1; #1;
    chk_bit("R10 fpwm pass", fpwm_o, 1'b1);
    go_off();
  endtask

  task automatic t_timeout_retry();
    en_i = 1; step(1);
    chk("R2 soft-start entry", E_RAMP);
    step(999);
    chk("R4 no early timeout", E_RAMP);
    step(1);
    chk("R4 R7 timeout fault", E_FAULT);
    step(29999);
    chk("R8 retry not early", E_FAULT);
    step(1);
    chk("R8 retry to soft-start", E_RAMP);
    step(500);
    en_i = 0; step(1);
    chk("R1 enable drop", E_OFF);
    en_i = 1; step(1);
    step(999);
    chk("R1 timer restarted", E_RAMP);
    step(1);
    chk("R4 timeout after restart", E_FAULT);
    go_off();
  endtask

  task automatic t_overcurrent();
    to_reg();
    ilim_i = 1; step(699);
    chk("R5 699 ticks", E_REG);
    ilim_i = 0; step(1);
    chk("R5 gap", E_REG);
    ilim_i = 1; step(699);
    chk("R5 count cleared by gap", E_REG);
    step(1);
    chk("R5 overcurrent fault", E_FAULT);
    go_off();
  endtask

  task automatic t_uvlo();
    to_reg();
    uvlo_i = 1; step(1);
    chk("R6 R7 uvlo fault", E_FAULT);
    step(100);
    uvlo_i = 0;
    step(29999);
    chk("R8 retry held during uvlo", E_FAULT);
    step(1);
    chk("R8 retry after uvlo", E_RAMP);
    go_off();
  endtask

  task automatic t_overtemp();
    to_reg();
    ot_hot_i = 1; step(1);
    ot_hot_i = 0;
    chk("R6 overtemp fault", E_FAULT);
    step(200);
    ot_cool_i = 1; step(1);
    ot_cool_i = 0;
    step(29999);
    chk("R6 overtemp latched", E_FAULT);
    step(1);
    chk("R8 retry after cool", E_RAMP);
    go_off();
  endtask

  task automatic t_passthrough();
    pt_req_i = 1; fpwm_req_i = 1;
    en_i = 1; step(1);
    chk("R9 pass-through entry", E_PASS);
    chk_bit("R10 fpwm masked", fpwm_o, 1'b0);
    ilim_i = 1; step(800);
    chk("R9 ilim ignored", E_PASS);
    ilim_i = 0; pt_req_i = 0; step(1);
    chk("R9 back to soft-start", E_RAMP);
    chk_bit("R10 fpwm unmasked", fpwm_o, 1'b1);
    pt_req_i = 1; step(1);
    chk("R9 ramp to pass-through", E_PASS);
    uvlo_i = 1; step(1);
    chk("R6 uvlo in pass-through", E_FAULT);
    go_off();
  endtask

  task automatic t_tick();
    tick_i = 0;
    en_i = 1; step(1);
    step(2000);
    chk("R11 no ticks no timeout", E_RAMP);
    for (int i = 0; i < 999; i++) begin
      tick_i = 1; step(1);
      tick_i = 0; step(3);
    end
    chk("R11 999 sparse ticks", E_RAMP);
    tick_i = 1; step(1);
    chk("R11 timeout on tick 1000", E_FAULT);
    go_off();
  endtask

  initial begin
    step(3);
    rst_ni = 1;
    step(1);
    chk("R1 reset state", E_OFF);
    t_bringup();
    t_timeout_retry();
    t_overcurrent();
    t_uvlo();
    t_overtemp();
    t_passthrough();
    t_tick();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule